// File: doc/BRIEF.md
# Execute-Stage Data Memory Access Unit

This unit carries loads and stores across the two execute stages of an in-order pipeline. It drives a single read/write port on a synchronous RAM that stores whole 32-bit words. The RAM returns read data one cycle after it receives the address. In execute 1 the unit issues a read of the word that holds the requested bytes. In execute 2 it either extracts the loaded value from the returned word, or merges new bytes into that word and writes the full word back. A store of a full word has nothing to merge, so it skips the read and only writes in execute 2.

Execute 2 can write to the port in the same cycle that execute 1 wants to read from it. The port cannot do both. In that case the write is served, the read is withheld, and a conflict flag tells the hazard controller to flush and replay the younger access. An access whose valid bit is low never touches the RAM.

Top module: `memAccessUnit`

## Requirements
- R1: A valid load presented in execute 1, with no conflict, raises ramRe in that same cycle with ramAddr equal to the byte address shifted right by two. In the following cycle loadValid is high and loadData carries the result.
- R2: Size code 0 is a byte. Address bits [1:0] pick the lane, where lane k is bits [8k+7:8k]. The loaded byte is sign-extended when reqSigned is 1 and zero-extended when it is 0.
- R3: Size code 1 is a halfword. Address bit 1 picks the upper half (bits 31:16) or the lower half (bits 15:0). The loaded halfword is extended according to reqSigned.
- R4: Size code 2 or 3 is a full word, and the load returns the RAM word unchanged.
- R5: A byte store reads the enclosing word in execute 1. In execute 2 it writes that word back with only the addressed lane replaced by reqWdata[7:0].
- R6: A halfword store reads the enclosing word in execute 1. In execute 2 it writes that word back with only the half selected by address bit 1 replaced by reqWdata[15:0].
- R7: A full-word store issues no read in execute 1. In the next cycle it writes reqWdata to the RAM.
- R8: When reqValid is low, no RAM read is issued in that cycle and no RAM write or loadValid follows in the next cycle.
- R9: When execute 2 is writing and a valid access in execute 1 needs a read, conflict is high and ramRe stays low. That access is dropped, so the next cycle shows no loadValid and no ramWe for it. A full-word store in execute 1 needs no read and raises no conflict.
- R10: After reset, ramRe, ramWe, loadValid and conflict are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Execute-1 access is valid |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| reqStore | input | 1 | 1 store, 0 load |
| reqSigned | input | 1 | Sign-extend sub-word loads |
| reqWdata | input | 32 | Store data, right-aligned |
| loadData | output | 32 | Extended load result (execute 2) |
| loadValid | output | 1 | loadData is valid this cycle |
| conflict | output | 1 | Port contention; the execute-1 access was dropped |
| ramAddr | output | ADDR_W-2 | RAM word address |
| ramRe | output | 1 | RAM read strobe |
| ramWe | output | 1 | RAM write strobe |
| ramWdata | output | 32 | RAM write word |
| ramRdata | input | 32 | RAM read word, one cycle after ramRe |

## Verification
The bench builds the unit with ADDR_W set to 10. This gives a 256-word RAM model that the bench keeps as a plain array, and every lane and half of a chosen word can be written and read back within a few cycles. The narrow address keeps the word-address shift visible: each check compares ramAddr with the byte address divided by four. The conflict scenario places a sub-word store directly ahead of a load, and separately places two full-word stores back to back, so both outcomes of the contention rule are reached.

// File: rtl/memAccessPkg.sv
package memAccessPkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WORD_ALT = 2'd3
  } accSize_t;

  typedef struct packed {
    logic issueRead;  // drive the execute-1 read on the port
    logic doWrite;    // execute 2 owns the port for a write
    logic capture;    // move the execute-1 access into execute 2
    logic ex2Load;    // execute 2 holds a load
  } memStrobe_t;
endpackage

// File: rtl/memAccessCtrl.sv
module memAccessCtrl
  import memAccessPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqSize,
  input  logic       reqStore,
  output memStrobe_t strobe,
  output logic       conflict,
  output logic       ramRe,
  output logic       ramWe,
  output logic       loadValid
);
  logic ex2Valid;
  logic ex2Store;
  logic fullWord;
  logic needRead;
  logic writeNow;

  assign fullWord = reqSize[1];
  assign needRead = reqValid && !(reqStore && fullWord);
  assign writeNow = ex2Valid && ex2Store;

  always_comb begin
    strobe.doWrite   = writeNow;
    strobe.issueRead = needRead && !writeNow;
    strobe.capture   = reqValid && !(needRead && writeNow);
    strobe.ex2Load   = ex2Valid && !ex2Store;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ex2Valid <= 1'b0;
      ex2Store <= 1'b0;
    end else begin
      ex2Valid <= strobe.capture;
      ex2Store <= reqStore;
    end
  end

  assign conflict  = needRead && writeNow;
  assign ramRe     = strobe.issueRead;
  assign ramWe     = strobe.doWrite;
  assign loadValid = strobe.ex2Load;
endmodule

// File: rtl/memAccessDatapath.sv
module memAccessDatapath
  import memAccessPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       ramRdata,
  output logic [ADDR_W-3:0] ramAddr,
  output logic [31:0]       ramWdata,
  output logic [31:0]       loadData
);
  localparam int WADDR_W = ADDR_W - 2;
  localparam int LANES   = 4;

  logic [WADDR_W-1:0] ex2Addr;
  logic [1:0]         ex2Lane;
  accSize_t           ex2Size;
  logic               ex2Signed;
  logic [31:0]        ex2Wdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ex2Addr   <= '0;
      ex2Lane   <= '0;
      ex2Size   <= SZ_WORD;
      ex2Signed <= 1'b0;
      ex2Wdata  <= '0;
    end else if (strobe.capture) begin
      ex2Addr   <= reqAddr[ADDR_W-1:2];
      ex2Lane   <= reqAddr[1:0];
      ex2Size   <= accSize_t'(reqSize);
      ex2Signed <= reqSigned;
      ex2Wdata  <= reqWdata;
    end
  end

  // Port address: the execute-2 write wins over the execute-1 read
  assign ramAddr = strobe.doWrite ? ex2Addr : reqAddr[ADDR_W-1:2];

  // Load extraction
  logic [31:0] byteShift;
  logic [31:0] halfShift;
  assign byteShift = ramRdata >> {ex2Lane, 3'b000};
  assign halfShift = ramRdata >> {ex2Lane[1], 4'b0000};

  always_comb begin
    unique case (ex2Size)
      SZ_BYTE: loadData = {{24{ex2Signed & byteShift[7]}}, byteShift[7:0]};
      SZ_HALF: loadData = {{16{ex2Signed & halfShift[15]}}, halfShift[15:0]};
      default: loadData = ramRdata;
    endcase
  end

  // Store merge
  logic [31:0] repData;
  always_comb begin
    unique case (ex2Size)
      SZ_BYTE: repData = {LANES{ex2Wdata[7:0]}};
      SZ_HALF: repData = {2{ex2Wdata[15:0]}};
      default: repData = ex2Wdata;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam logic [1:0] LANE_ID = 2'(g);
    logic laneEn;
    always_comb begin
      unique case (ex2Size)
        SZ_BYTE: laneEn = (ex2Lane == LANE_ID);
        SZ_HALF: laneEn = (ex2Lane[1] == LANE_ID[1]);
        default: laneEn = 1'b1;
      endcase
    end
    assign ramWdata[8*g +: 8] = laneEn ? repData[8*g +: 8] : ramRdata[8*g +: 8];
  end
endmodule

// File: rtl/memAccessUnit.sv
module memAccessUnit
  import memAccessPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqStore,
  input  logic              reqSigned,
  input  logic [31:0]       reqWdata,
  output logic [31:0]       loadData,
  output logic              loadValid,
  output logic              conflict,
  output logic [ADDR_W-3:0] ramAddr,
  output logic              ramRe,
  output logic              ramWe,
  output logic [31:0]       ramWdata,
  input  logic [31:0]       ramRdata
);
  memStrobe_t strobe;

  memAccessCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSize(reqSize),
    .reqStore(reqStore), .strobe(strobe), .conflict(conflict),
    .ramRe(ramRe), .ramWe(ramWe), .loadValid(loadValid)
  );

  memAccessDatapath #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqSigned(reqSigned), .reqWdata(reqWdata),
    .ramRdata(ramRdata), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .loadData(loadData)
  );
endmodule

// File: rtl/memAccessChk.sv
module memAccessChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqSize,
  input logic              reqStore,
  input logic [31:0]       reqWdata,
  input logic              loadValid,
  input logic              conflict,
  input logic              ramRe,
  input logic              ramWe,
  input logic [31:0]       ramWdata
);
  // R8
  idle_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !ramRe);
  // R8
  idle_no_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(ramWe || loadValid));
  // R9
  conflict_blocks_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    conflict |-> (!ramRe && ramWe));
  // R9
  conflict_drops_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    conflict |=> !(ramWe || loadValid));
  // R9
  port_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ramRe && ramWe));
  // R1
  read_completes_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramRe |=> $onehot({loadValid, ramWe}));
  // R7
  word_store_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqStore && reqSize[1]) |-> (!ramRe && !conflict));
  // R7
  word_store_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqStore && reqSize[1]) |=> (ramWe && ramWdata == $past(reqWdata)));
  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> !(ramRe || ramWe || loadValid || conflict) || !rstN || reqValid);
endmodule

bind memAccessUnit memAccessChk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_memAccessUnit.sv
module test_memAccessUnit;
  localparam int ADDR_W = 10;
  localparam int WORDS  = 256;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic [ADDR_W-1:0] reqAddr;
  logic [1:0]        reqSize;
  logic              reqStore;
  logic              reqSigned;
  logic [31:0]       reqWdata;
  logic [31:0]       loadData;
  logic              loadValid;
  logic              conflict;
  logic [ADDR_W-3:0] ramAddr;
  logic              ramRe;
  logic              ramWe;
  logic [31:0]       ramWdata;
  logic [31:0]       ramRdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  memAccessUnit #(.ADDR_W(ADDR_W)) i_memAccessUnit (.*);

  logic [31:0] mem [WORDS];
  always @(posedge clk) begin
    if (ramWe) mem[ramAddr] <= ramWdata;
    if (ramRe) ramRdata <= mem[ramAddr];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 1'b0; reqStore = 1'b0; reqSize = 2'd0; reqSigned = 1'b0;
  endtask

  task automatic doStore(input string req, input logic [ADDR_W-1:0] a,
                         input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSize = sz; reqStore = 1'b1; reqWdata = d;
    #1;
    check({req, " read strobe"}, {31'd0, ramRe}, {31'd0, !sz[1]});
    check({req, " no conflict"}, {31'd0, conflict}, 32'd0);
    @(negedge clk);
    idle();
    #1;
    check({req, " write strobe"}, {31'd0, ramWe}, 32'd1);
    check({req, " write addr"}, 32'(ramAddr), 32'(a >> 2));
  endtask

  task automatic doLoad(input string req, input logic [ADDR_W-1:0] a,
                        input logic [1:0] sz, input logic sgn, input logic [31:0] exp);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSize = sz; reqStore = 1'b0; reqSigned = sgn;
    #1;
    check({req, " read strobe"}, {31'd0, ramRe}, 32'd1);
    check({req, " read addr"}, 32'(ramAddr), 32'(a >> 2));
    @(negedge clk);
    idle();
    #1;
    check({req, " loadValid"}, {31'd0, loadValid}, 32'd1);
    check({req, " data"}, loadData, exp);
  endtask

  task automatic testReset();
    check("R10 ramRe", {31'd0, ramRe}, 32'd0);
    check("R10 ramWe", {31'd0, ramWe}, 32'd0);
    check("R10 loadValid", {31'd0, loadValid}, 32'd0);
    check("R10 conflict", {31'd0, conflict}, 32'd0);
  endtask

  task automatic testWord();
    doStore("R7 word store", 10'h040, 2'd2, 32'h11223344);
    doLoad("R4 R1 word load", 10'h040, 2'd2, 1'b0, 32'h11223344);
    doLoad("R4 size3 load", 10'h040, 2'd3, 1'b1, 32'h11223344);
  endtask

  task automatic testByte();
    doStore("R5 byte store lane1", 10'h041, 2'd0, 32'hFFFFFFAA);
    doLoad("R5 merge check", 10'h040, 2'd2, 1'b0, 32'h1122AA44);
    doLoad("R2 signed lane1", 10'h041, 2'd0, 1'b1, 32'hFFFFFFAA);
    doLoad("R2 unsigned lane1", 10'h041, 2'd0, 1'b0, 32'h000000AA);
    doLoad("R2 signed lane0 positive", 10'h040, 2'd0, 1'b1, 32'h00000044);
    doStore("R5 byte store lane3", 10'h043, 2'd0, 32'h0000007F);
    doLoad("R5 lane3 merge", 10'h040, 2'd2, 1'b0, 32'h7F22AA44);
  endtask

  task automatic testHalf();
    doStore("R6 half store upper", 10'h042, 2'd1, 32'h1234BEEF);
    doLoad("R6 merge check", 10'h040, 2'd2, 1'b0, 32'hBEEFAA44);
    doLoad("R3 signed upper", 10'h042, 2'd1, 1'b1, 32'hFFFFBEEF);
    doLoad("R3 unsigned upper", 10'h042, 2'd1, 1'b0, 32'h0000BEEF);
    doLoad("R3 signed lower", 10'h040, 2'd1, 1'b1, 32'hFFFFAA44);
    doStore("R6 half store lower", 10'h040, 2'd1, 32'h00000102);
    doLoad("R6 lower merge", 10'h040, 2'd2, 1'b0, 32'hBEEF0102);
  endtask

  task automatic testInvalid();
    @(negedge clk);
    reqValid = 1'b0; reqAddr = 10'h040; reqSize = 2'd2; reqStore = 1'b1;
    reqWdata = 32'hDEADBEEF;
    #1;
    check("R8 no read", {31'd0, ramRe}, 32'd0);
    @(negedge clk);
    idle();
    #1;
    check("R8 no write", {31'd0, ramWe}, 32'd0);
    check("R8 no loadValid", {31'd0, loadValid}, 32'd0);
    doLoad("R8 word untouched", 10'h040, 2'd2, 1'b0, 32'hBEEF0102);
  endtask

  task automatic testConflict();
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 10'h080; reqSize = 2'd0; reqStore = 1'b1;
    reqWdata = 32'h000000C3;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 10'h040; reqSize = 2'd2; reqStore = 1'b0;
    #1;
    check("R9 conflict raised", {31'd0, conflict}, 32'd1);
    check("R9 read withheld", {31'd0, ramRe}, 32'd0);
    check("R9 write served", {31'd0, ramWe}, 32'd1);
    @(negedge clk);
    idle();
    #1;
    check("R9 dropped no loadValid", {31'd0, loadValid}, 32'd0);
    check("R9 dropped no write", {31'd0, ramWe}, 32'd0);
    doLoad("R9 store landed", 10'h080, 2'd2, 1'b0, 32'h000000C3);
    // back-to-back full-word stores share the port without conflict
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 10'h084; reqSize = 2'd2; reqStore = 1'b1;
    reqWdata = 32'hCAFE0001;
    @(negedge clk);
    reqAddr = 10'h088; reqWdata = 32'hCAFE0002;
    #1;
    check("R9 word store no conflict", {31'd0, conflict}, 32'd0);
    @(negedge clk);
    idle();
    #1;
    check("R7 second write", {31'd0, ramWe}, 32'd1);
    check("R7 second data", ramWdata, 32'hCAFE0002);
    doLoad("R7 first word", 10'h084, 2'd2, 1'b0, 32'hCAFE0001);
    doLoad("R7 second word", 10'h088, 2'd2, 1'b0, 32'hCAFE0002);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = 32'd0;
    rstN = 1'b0; reqAddr = '0; reqWdata = '0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testWord();
    testByte();
    testHalf();
    testInvalid();
    testConflict();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule